// File: doc/BRIEF.md
# Bus Reset and Configuration Sequencer

This block owns the reset line of a processor bus. It starts a full power-on sequence whenever the power-good input is low. It also accepts a warm-reset request at any later time. In both cases the active-low bus reset is held until a programmed number of qualifying reference-clock cycles has elapsed. A cycle qualifies when the clock-stable input is high and no warm request is present. On power-on the count therefore starts once the clock is stable. On a warm reset it starts when the request goes away. A request that arrives during a count pushes the release out.

While the bus is in reset, the block gates the bus-output enable low within one clock. It raises a writeback-inhibit level and emits a single-cycle cache-invalidate pulse near the start of every reset period. On the clock edge that releases reset it captures the configuration strap bus into a held word. In the first cycle after release it gives a start-execution strobe, unless the strap value captured at that edge asks for the bus outputs to stay tristated.

Top module: `bus_reset_seq`

## Requirements
- R1: After power-good goes high, `bus_rst_n_o` stays low until HOLD_CYC consecutive clock edges have seen `clk_stable_i` high and `warm_req_i` low; a non-qualifying edge restarts that run from zero, and the release happens on the HOLD_CYC-th qualifying edge.
- R2: While `pwr_good_i` is low the block is reset asynchronously: `bus_rst_n_o`, `bus_oe_o`, `inval_o` and `start_exec_o` are 0, `cfg_o` is all zeros and `wb_inhibit_o` is 1, and the full count of R1 restarts.
- R3: With reset released, a clock edge that sees `warm_req_i` high drives `bus_rst_n_o` low; release then follows the same qualifying-run rule as R1.
- R4: A warm request seen during a reset hold never shortens it: the qualifying run restarts, so release comes HOLD_CYC qualifying edges after the last request edge.
- R5: `bus_oe_o` equals `bus_oe_req_i` only when `bus_rst_n_o` was high before the most recent clock edge; it is 0 from one clock after `bus_rst_n_o` falls at the latest, and it stays 0 until one clock after release.
- R6: `cfg_o` loads `strap_i` on the clock edge where `bus_rst_n_o` rises and holds that value unchanged, through any later warm reset, until the next release edge.
- R7: Each reset period yields exactly one `inval_o` pulse of one cycle. It is high in the cycle after the first clock edge of the period, while reset is still asserted. `wb_inhibit_o` is 1 exactly while `bus_rst_n_o` is 0.
- R8: `start_exec_o` is a one-cycle pulse in the cycle right after a release edge. It occurs only if strap bit TRI_BIT (bit 7 with the default CFG_W of 8) was 0 at that edge, and it never occurs at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| pwr_good_i | input | 1 | Power good; low asynchronously restarts the power-on sequence |
| clk_stable_i | input | 1 | Clock-stable indication; qualifies counting |
| warm_req_i | input | 1 | Warm-reset request, level sampled each clock |
| strap_i | input | CFG_W | Configuration strap inputs |
| bus_oe_req_i | input | 1 | Output-enable request from the bus interface |
| bus_rst_n_o | output | 1 | Active-low bus reset |
| bus_oe_o | output | 1 | Gated bus-output enable |
| wb_inhibit_o | output | 1 | Writeback inhibit, high during reset |
| inval_o | output | 1 | One-cycle cache-invalidate pulse |
| start_exec_o | output | 1 | One-cycle start-execution strobe |
| cfg_o | output | CFG_W | Configuration word captured at release |

## Verification
A wrong hold counter shows up as a release edge that comes early or late, visible on `bus_rst_n_o` in the very cycle of the error. The reference model in the bench measures it to the exact edge after both clock-stable glitches and repeated warm requests. A stale output-enable kill register lets `bus_oe_o` follow its request for one or more cycles too many after reset falls, or too few after release. A capture at the wrong edge, or a capture with no release, changes `cfg_o` at once. A bad invalidate-done flag or start decision gives a missing, doubled or misplaced strobe in the cycle after the affected edge.

// File: rtl/brs_pkg.sv
package brs_pkg;

  // True when the qualifying edge now being seen completes the hold run.
  function automatic logic hold_reached(input int unsigned done_edges,
                                        input int unsigned hold_edges);
    return (done_edges + 1) >= hold_edges;
  endfunction

  // Output enable passes only when the kill flag is clear.
  function automatic logic gate_enable(input logic req, input logic kill);
    return req & ~kill;
  endfunction

  // A start strobe is due when the release is not vetoed by the tristate strap.
  function automatic logic start_allowed(input logic rel, input logic tri_strap);
    return rel & ~tri_strap;
  endfunction

endpackage

// File: rtl/brs_hold_timer.sv
module brs_hold_timer #(
  parameter int unsigned HOLD_CYC = 50000,
  parameter int unsigned CNT_W    = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic clk_stable_i,
  input  logic warm_req_i,
  output logic rst_active_o,
  output logic assert_evt_o,
  output logic release_evt_o
);
  import brs_pkg::*;

  logic [CNT_W-1:0] run_q;
  logic             active_q;
  logic             qualify;

  always_comb begin
    qualify       = clk_stable_i & ~warm_req_i;
    release_evt_o = active_q & qualify & hold_reached(32'(run_q), HOLD_CYC);
    assert_evt_o  = ~active_q & warm_req_i;
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      active_q <= 1'b1;
      run_q    <= '0;
    end else if (active_q) begin
      if (!qualify) begin
        run_q <= '0;
      end else if (release_evt_o) begin
        active_q <= 1'b0;
        run_q    <= '0;
      end else begin
        run_q <= run_q + CNT_W'(1);
      end
    end else if (assert_evt_o) begin
      active_q <= 1'b1;
      run_q    <= '0;
    end
  end

  assign rst_active_o = active_q;

endmodule

// File: rtl/brs_strap_capture.sv
module brs_strap_capture #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             arst_n_i,
  input  logic             capture_i,
  input  logic [CFG_W-1:0] strap_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      word_q <= '0;
    end else if (capture_i) begin
      word_q <= strap_i;
    end
  end

  assign cfg_o = word_q;

endmodule

// File: rtl/brs_event_gen.sv
module brs_event_gen (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic rst_active_i,
  input  logic release_evt_i,
  input  logic tri_strap_i,
  input  logic oe_req_i,
  output logic inval_o,
  output logic start_o,
  output logic oe_o
);
  import brs_pkg::*;

  logic inval_q;
  logic inval_done_q;
  logic start_q;
  logic kill_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      inval_q      <= 1'b0;
      inval_done_q <= 1'b0;
      start_q      <= 1'b0;
      kill_q       <= 1'b1;
    end else begin
      inval_q      <= rst_active_i & ~inval_done_q;
      inval_done_q <= rst_active_i;
      start_q      <= start_allowed(release_evt_i, tri_strap_i);
      kill_q       <= rst_active_i;
    end
  end

  assign inval_o = inval_q;
  assign start_o = start_q;
  assign oe_o    = gate_enable(oe_req_i, kill_q);

endmodule

// File: rtl/bus_reset_seq.sv
module bus_reset_seq #(
  parameter int unsigned HOLD_CYC = 50000,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned TRI_BIT  = 7
) (
  input  logic             clk_i,
  input  logic             pwr_good_i,
  input  logic             clk_stable_i,
  input  logic             warm_req_i,
  input  logic [CFG_W-1:0] strap_i,
  input  logic             bus_oe_req_i,
  output logic             bus_rst_n_o,
  output logic             bus_oe_o,
  output logic             wb_inhibit_o,
  output logic             inval_o,
  output logic             start_exec_o,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);

  logic rst_active;
  logic assert_evt;
  logic release_evt;
  logic tri_strap;

  assign tri_strap = strap_i[TRI_BIT];

  brs_hold_timer #(.HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)) u_timer (
    .clk_i        (clk_i),
    .arst_n_i     (pwr_good_i),
    .clk_stable_i (clk_stable_i),
    .warm_req_i   (warm_req_i),
    .rst_active_o (rst_active),
    .assert_evt_o (assert_evt),
    .release_evt_o(release_evt)
  );

  brs_strap_capture #(.CFG_W(CFG_W)) u_straps (
    .clk_i    (clk_i),
    .arst_n_i (pwr_good_i),
    .capture_i(release_evt),
    .strap_i  (strap_i),
    .cfg_o    (cfg_o)
  );

  brs_event_gen u_events (
    .clk_i        (clk_i),
    .arst_n_i     (pwr_good_i),
    .rst_active_i (rst_active),
    .release_evt_i(release_evt),
    .tri_strap_i  (tri_strap),
    .oe_req_i     (bus_oe_req_i),
    .inval_o      (inval_o),
    .start_o      (start_exec_o),
    .oe_o         (bus_oe_o)
  );

  assign bus_rst_n_o  = ~rst_active;
  assign wb_inhibit_o = rst_active;

endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int unsigned HOLD_CYC = 50000,
  parameter int unsigned CFG_W    = 8
) (
  input logic             clk_i,
  input logic             pwr_good_i,
  input logic             clk_stable_i,
  input logic             warm_req_i,
  input logic             bus_rst_n_o,
  input logic             bus_oe_o,
  input logic             inval_o,
  input logic             start_exec_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             assert_evt,
  input logic             release_evt
);
  logic [31:0] low_run;

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) low_run <= '0;
    else if (!bus_rst_n_o) low_run <= (low_run == 32'hFFFF_FFFF) ? low_run : low_run + 32'd1;
    else low_run <= '0;
  end

  AST_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    $rose(bus_rst_n_o) |-> (low_run >= HOLD_CYC)); // R1
  AST_RELEASE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    $rose(bus_rst_n_o) |-> $past(clk_stable_i && !warm_req_i)); // R1
  AST_RELEASE_EVT: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    release_evt |=> bus_rst_n_o); // R1
  AST_WARM_ENTER: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    assert_evt |=> !bus_rst_n_o); // R3
  AST_WARM_EXTEND: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (!bus_rst_n_o && warm_req_i) |=> !bus_rst_n_o); // R4
  AST_OE_KILLED: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (!bus_rst_n_o && $past(!bus_rst_n_o)) |-> !bus_oe_o); // R5
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    !$rose(bus_rst_n_o) |-> $stable(cfg_o)); // R6
  AST_INVAL_SINGLE: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    inval_o |=> !inval_o); // R7
  AST_INVAL_IN_RESET: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    inval_o |-> !bus_rst_n_o); // R7
  AST_START_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    start_exec_o |-> $rose(bus_rst_n_o)); // R8

endmodule

bind bus_reset_seq brs_checker #(.HOLD_CYC(HOLD_CYC), .CFG_W(CFG_W)) u_chk (
  .clk_i       (clk_i),
  .pwr_good_i  (pwr_good_i),
  .clk_stable_i(clk_stable_i),
  .warm_req_i  (warm_req_i),
  .bus_rst_n_o (bus_rst_n_o),
  .bus_oe_o    (bus_oe_o),
  .inval_o     (inval_o),
  .start_exec_o(start_exec_o),
  .cfg_o       (cfg_o),
  .assert_evt  (assert_evt),
  .release_evt (release_evt)
);

// File: tb/tb_bus_reset_seq.sv
module tb_bus_reset_seq;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic       clk_stable = 1'b0;
  logic       warm_req = 1'b0;
  logic [7:0] strap = 8'h00;
  logic       oe_req = 1'b0;
  logic       rst_n, oe, wb_inh, inval, start;
  logic [7:0] cfg;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  bus_reset_seq #(.HOLD_CYC(HOLD), .CFG_W(8), .TRI_BIT(7)) dut (
    .clk_i(clk), .pwr_good_i(pwr_good), .clk_stable_i(clk_stable),
    .warm_req_i(warm_req), .strap_i(strap), .bus_oe_req_i(oe_req),
    .bus_rst_n_o(rst_n), .bus_oe_o(oe), .wb_inhibit_o(wb_inh),
    .inval_o(inval), .start_exec_o(start), .cfg_o(cfg));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: counts edges and ages rather than modelling registers.
  bit in_reset = 1'b1;
  int good_run = 0;
  int age      = 0;
  bit m_kill   = 1'b1;
  bit m_inval  = 1'b0;
  bit m_start  = 1'b0;
  int m_cfg    = 0;

  always @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      in_reset = 1'b1; good_run = 0; age = 0;
      m_kill = 1'b1; m_inval = 1'b0; m_start = 1'b0; m_cfg = 0;
    end else begin
      automatic bit was_reset = in_reset;
      automatic bit freed = 1'b0;
      if (was_reset) begin
        good_run = (clk_stable && !warm_req) ? good_run + 1 : 0;
        if (good_run >= HOLD) begin
          in_reset = 1'b0; freed = 1'b1; good_run = 0; m_cfg = int'(strap);
        end
        age++;
      end else if (warm_req) begin
        in_reset = 1'b1; good_run = 0; age = 0;
      end
      m_inval = was_reset && (age == 1);
      m_start = freed && !strap[7];
      m_kill  = was_reset;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk(rst_n == !in_reset, "R1 R3 bus reset", int'(rst_n), int'(!in_reset));
      chk(oe == (oe_req && !m_kill), "R5 output enable", int'(oe), int'(oe_req && !m_kill));
      chk(cfg == m_cfg[7:0], "R6 config word", int'(cfg), m_cfg);
      chk(inval == m_inval, "R7 invalidate", int'(inval), int'(m_inval));
      chk(wb_inh == in_reset, "R7 writeback inhibit", int'(wb_inh), int'(in_reset));
      chk(start == m_start, "R8 start strobe", int'(start), int'(m_start));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic warm_pulse();
    step(); warm_req = 1'b1;
    step(); warm_req = 1'b0;
  endtask

  task automatic count_low(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (rst_n) break;
      n++;
    end
  endtask

  int n;

  initial begin
    step();
    cmp_on = 1'b1;
    @(negedge clk);
    chk(rst_n == 1'b0 && oe == 1'b0 && cfg == 8'h00 && wb_inh == 1'b1,
        "R2 reset state", {rst_n, oe, wb_inh}, 3'b001);

    // R1: power good but clock not stable: no release
    step(); pwr_good = 1'b1; oe_req = 1'b1; strap = 8'h5A;
    repeat (HOLD + 3) step();
    chk(rst_n == 1'b0, "R1 held without stable clock", int'(rst_n), 0);
    clk_stable = 1'b1;
    repeat (4) step();
    clk_stable = 1'b0;
    step(); clk_stable = 1'b1;
    count_low(n);
    chk(n == HOLD, "R1 power-on run after glitch", n, HOLD);
    chk(cfg == 8'h5A, "R6 straps captured at release", int'(cfg), 8'h5A);
    chk(start == 1'b1, "R8 start after release", int'(start), 1);
    @(negedge clk);
    chk(oe == 1'b1 && start == 1'b0, "R5 enable follows request", {oe, start}, 2'b10);

    // R3 / R5 / R7: warm reset
    strap = 8'h33;
    repeat (3) step();
    chk(cfg == 8'h5A, "R6 straps ignored while running", int'(cfg), 8'h5A);
    step(); warm_req = 1'b1;
    step(); warm_req = 1'b0;
    @(negedge clk);
    chk(rst_n == 1'b0, "R3 warm request asserts reset", int'(rst_n), 0);
    @(negedge clk);
    chk(oe == 1'b0 && inval == 1'b1, "R5 R7 enable killed, invalidate", {oe, inval}, 2'b01);
    strap = 8'h81;
    count_low(n);
    chk(n == HOLD - 2, "R3 warm hold length", n, HOLD - 2);
    chk(cfg == 8'h81, "R6 new straps at warm release", int'(cfg), 8'h81);
    chk(start == 1'b0, "R8 tristate strap vetoes start", int'(start), 0);

    // R4: request during the hold extends it
    strap = 8'h24;
    warm_pulse();
    repeat (HOLD - 3) @(negedge clk);
    chk(rst_n == 1'b0, "R4 still held mid count", int'(rst_n), 0);
    warm_pulse();
    count_low(n);
    chk(n == HOLD, "R4 run restarted by second request", n, HOLD);
    chk(cfg == 8'h24 && start == 1'b1, "R6 R8 release after extension", {cfg, start}, {8'h24, 1'b1});

    // R2: power loss in the running state
    strap = 8'h11;
    repeat (3) step();
    pwr_good = 1'b0;
    #1;
    chk(rst_n == 1'b0 && oe == 1'b0 && cfg == 8'h00, "R2 power loss resets",
        {rst_n, oe, cfg}, 10'h000);
    repeat (3) step();
    pwr_good = 1'b1;
    count_low(n);
    chk(n == HOLD, "R1 R2 full power-on count", n, HOLD);
    chk(cfg == 8'h11, "R6 capture after power-on", int'(cfg), 8'h11);

    // R5 with request toggling while running
    oe_req = 1'b0;
    @(negedge clk);
    chk(oe == 1'b0, "R5 enable follows low request", int'(oe), 0);
    repeat (4) step();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule